// File: doc/BRIEF.md
# Static Block-Floating-Point Multiply-Accumulate with Requantization

This block computes one output of a convolution layer whose activations and weights are stored as 8-bit signed mantissas with shared exponents fixed before inference. A whole group of terms shares one activation exponent and one weight exponent: activations are grouped by temporal frame and weights by output filter. Because of this, the products of one window can be summed as plain integers. The accumulator is wide enough that a window of up to `MAX_TERMS` full-scale products cannot overflow.

When the last term of a window is accepted, the sum is converted to the next layer's 8-bit mantissa by one arithmetic shift. Its amount is the difference between the exponents of the two layers. It is read from a small table indexed by the frame and filter presented with that last term. The table is written through plain configuration pins before inference. No exponent is found or compared at run time, and no floating-point format appears anywhere.

Mantissa pairs enter on a valid/ready stream and results leave on a valid/ready stream. A result stays on the output until the consumer takes it. While a result is held and `out_ready` is low, `in_ready` is low and every input term is stalled. In all other cycles, one term is accepted per clock.

Top module: `sbfp_mac_requant`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1. Every entry of the shift table resets to 0, which means a pass-through shift.
- R2: A result equals the requantized two's-complement sum of `in_act*in_wgt` over all accepted terms from the first term of a window through the term carrying `in_last`=1.
- R3: For windows of at most `MAX_TERMS` terms, the sum is exact for any mantissa values, including a full window of -128 x -128 products.
- R4: `out_valid` rises in the cycle after the last term of a window is accepted, and each window produces exactly one result.
- R5: A cycle with `cfg_we`=1 stores the signed `cfg_shift` at entry (`cfg_frame`, `cfg_filter`). A result uses the entry selected by `in_frame` and `in_filter` sampled with its last term.
- R6: A positive shift amount n divides the sum by 2^n and rounds to nearest, with ties going away from zero (6>>2 gives 2, -6>>2 gives -2, 5>>2 gives 1).
- R7: A negative shift amount -n multiplies the sum by 2^n. A zero amount leaves the sum unchanged.
- R8: After shifting, the result saturates to the range -128 to +127.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` holds its value and `in_ready` is 0. Terms presented in those cycles are ignored.
- R10: Cycles with `in_valid`=0 add nothing to the sum. The first accepted term after a last term starts a new sum from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Shift table write strobe |
| cfg_frame | input | FRAME_W (2) | Frame index of the entry to write |
| cfg_filter | input | FILT_W (3) | Filter index of the entry to write |
| cfg_shift | input | SHIFT_W (6) | Signed shift amount; positive means right, negative means left |
| in_valid | input | 1 | Term present |
| in_ready | output | 1 | Term will be accepted on this edge if valid |
| in_act | input | 8 | Signed activation mantissa |
| in_wgt | input | 8 | Signed weight mantissa |
| in_last | input | 1 | Final term of the window |
| in_frame | input | FRAME_W (2) | Temporal block index, used with the last term |
| in_filter | input | FILT_W (3) | Output filter index, used with the last term |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_data | output | 8 | Signed output mantissa |

## Verification
The assertions assume two things about the inputs. First, no window carries more than `MAX_TERMS` accepted terms, since the accumulator width is sized on that bound. Second, configuration writes only address frames and filters that exist. The stimulus draws window lengths between 1 and `MAX_TERMS` and draws table indices only inside the configured counts. It writes the table only in cycles with no term in flight, so the rounding, shifting and saturation results can be predicted from the table contents alone. Random gaps in `in_valid` and random stalls on `out_ready` exercise the hold and ignore rules. Among the directed windows is a full window of the most negative mantissas.

// File: rtl/sbfp_pkg.sv
package sbfp_pkg;
  localparam int MANT_W = 8;
  localparam int PROD_W = 2 * MANT_W;
  typedef logic signed [MANT_W-1:0] mant_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  localparam int OUT_MAX = (1 << (MANT_W - 1)) - 1;
  localparam int OUT_MIN = -(1 << (MANT_W - 1));
endpackage

// File: rtl/sbfp_shift_table.sv
module sbfp_shift_table #(
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_FILTERS = 8,
  parameter int SHIFT_W     = 6,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int FILT_W  = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1,
  localparam int DEPTH   = NUM_FRAMES * NUM_FILTERS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [FRAME_W-1:0]        wr_frame,
  input  logic [FILT_W-1:0]         wr_filter,
  input  logic signed [SHIFT_W-1:0] wr_shift,
  input  logic [FRAME_W-1:0]        rd_frame,
  input  logic [FILT_W-1:0]         rd_filter,
  output logic signed [SHIFT_W-1:0] rd_shift
);
  logic signed [SHIFT_W-1:0] entry [DEPTH];
  int unsigned wr_idx, rd_idx;

  assign wr_idx = 32'(wr_frame) * NUM_FILTERS + 32'(wr_filter);
  assign rd_idx = 32'(rd_frame) * NUM_FILTERS + 32'(rd_filter);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry[g] <= '0;
      else if (wr_en && wr_idx == g) entry[g] <= wr_shift;
    end
  end

  always_comb begin
    rd_shift = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == i) rd_shift = entry[i];
  end
endmodule

// File: rtl/sbfp_accum.sv
module sbfp_accum
  import sbfp_pkg::*;
#(
  parameter int ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    last,
  input  mant_t                   act,
  input  mant_t                   wgt,
  output logic signed [ACC_W-1:0] sum_now
);
  logic signed [ACC_W-1:0] acc_q;
  logic                    fresh_q;
  prod_t                   prod;

  assign prod    = act * wgt;
  assign sum_now = (fresh_q ? '0 : acc_q) + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      fresh_q <= 1'b1;
    end else if (take) begin
      acc_q   <= sum_now;
      fresh_q <= last;
    end
  end
endmodule

// File: rtl/sbfp_requant.sv
module sbfp_requant
  import sbfp_pkg::*;
#(
  parameter int ACC_W   = 22,
  parameter int SHIFT_W = 6,
  localparam int LMAX = 1 << (SHIFT_W - 1),
  localparam int WIDE = ACC_W + LMAX + 1
) (
  input  logic signed [ACC_W-1:0]   value,
  input  logic signed [SHIFT_W-1:0] shift,
  output mant_t                     mant
);
  localparam logic signed [WIDE-1:0] HI = WIDE'(OUT_MAX);
  localparam logic signed [WIDE-1:0] LO = WIDE'(OUT_MIN);

  logic signed [WIDE-1:0] wide_v, mag, half, rnd, res;
  logic [SHIFT_W-1:0]     amt;
  logic                   neg;

  always_comb begin
    wide_v = {{(WIDE-ACC_W){value[ACC_W-1]}}, value};
    neg    = value[ACC_W-1];
    mag    = neg ? -wide_v : wide_v;
    half   = '0;
    rnd    = '0;
    if (!shift[SHIFT_W-1]) begin
      amt = shift;
      if (amt != '0) half = WIDE'(1) << (amt - 1'b1);
      rnd = (mag + half) >> amt;
      res = neg ? -rnd : rnd;
    end else begin
      amt = -shift;
      res = wide_v <<< amt;
    end
    if (res > HI)      mant = mant_t'(OUT_MAX);
    else if (res < LO) mant = mant_t'(OUT_MIN);
    else               mant = res[MANT_W-1:0];
  end
endmodule

// File: rtl/sbfp_mac_requant.sv
module sbfp_mac_requant
  import sbfp_pkg::*;
#(
  parameter int MAX_TERMS   = 64,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_FILTERS = 8,
  parameter int SHIFT_W     = 6,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int FILT_W  = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1,
  localparam int ACC_W   = PROD_W + $clog2(MAX_TERMS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [FRAME_W-1:0]        cfg_frame,
  input  logic [FILT_W-1:0]         cfg_filter,
  input  logic signed [SHIFT_W-1:0] cfg_shift,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic signed [MANT_W-1:0]  in_act,
  input  logic signed [MANT_W-1:0]  in_wgt,
  input  logic                      in_last,
  input  logic [FRAME_W-1:0]        in_frame,
  input  logic [FILT_W-1:0]         in_filter,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic signed [MANT_W-1:0]  out_data
);
  logic                      take;
  logic signed [ACC_W-1:0]   sum_now;
  logic signed [SHIFT_W-1:0] sel_shift;
  mant_t                     q_mant;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  sbfp_shift_table #(
    .NUM_FRAMES(NUM_FRAMES), .NUM_FILTERS(NUM_FILTERS), .SHIFT_W(SHIFT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_frame(cfg_frame), .wr_filter(cfg_filter), .wr_shift(cfg_shift),
    .rd_frame(in_frame), .rd_filter(in_filter), .rd_shift(sel_shift)
  );

  sbfp_accum #(.ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .take(take), .last(in_last),
    .act(in_act), .wgt(in_wgt), .sum_now(sum_now)
  );

  sbfp_requant #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_requant (
    .value(sum_now), .shift(sel_shift), .mant(q_mant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take && in_last) begin
      out_valid <= 1'b1;
      out_data  <= q_mant;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sbfp_mac_requant_chk.sv
module sbfp_mac_requant_chk #(
  parameter int MAX_TERMS   = 64,
  parameter int NUM_FRAMES  = 4,
  parameter int NUM_FILTERS = 8,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int FILT_W  = (NUM_FILTERS > 1) ? $clog2(NUM_FILTERS) : 1,
  localparam int CNT_W   = $clog2(MAX_TERMS + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [FRAME_W-1:0] cfg_frame,
  input logic [FILT_W-1:0]  cfg_filter,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_last,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data
);
  logic             acc_t;
  logic [CNT_W-1:0] win_cnt;

  assign acc_t = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_cnt <= '0;
    else if (acc_t) win_cnt <= in_last ? '0 : win_cnt + 1'b1;
  end

  // R1: reset forces the output idle
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3: accumulator sizing assumes bounded windows
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t |-> (win_cnt < CNT_W'(MAX_TERMS)));

  // R4: result one cycle after the closing term
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_t && in_last |=> out_valid);

  // R4: no result without a closing term
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_t && in_last));

  // R4: a taken result with no new closing term leaves the output idle
  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(acc_t && in_last) |=> !out_valid);

  // R9: a stalled result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5: table writes stay inside the configured table
  a_r5_cfg_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (32'(cfg_frame) < NUM_FRAMES) && (32'(cfg_filter) < NUM_FILTERS));
endmodule

bind sbfp_mac_requant sbfp_mac_requant_chk #(
  .MAX_TERMS(MAX_TERMS), .NUM_FRAMES(NUM_FRAMES), .NUM_FILTERS(NUM_FILTERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
  .cfg_filter(cfg_filter), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/sbfp_mac_requant_bench.sv
`timescale 1ns/1ps
module sbfp_mac_requant_bench;
  localparam int MAX_TERMS = 64;
  localparam int NFR = 4;
  localparam int NFI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_frame = '0;
  logic [2:0] cfg_filter = '0;
  logic signed [5:0] cfg_shift = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [7:0] in_act = '0, in_wgt = '0;
  logic in_last = 1'b0;
  logic [1:0] in_frame = '0;
  logic [2:0] in_filter = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [7:0] out_data;

  always #2 clk = ~clk;

  sbfp_mac_requant #(.MAX_TERMS(MAX_TERMS), .NUM_FRAMES(NFR), .NUM_FILTERS(NFI), .SHIFT_W(6))
  u_sbfp_mac_requant (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
    .cfg_filter(cfg_filter), .cfg_shift(cfg_shift), .in_valid(in_valid),
    .in_ready(in_ready), .in_act(in_act), .in_wgt(in_wgt), .in_last(in_last),
    .in_frame(in_frame), .in_filter(in_filter), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int shadow [NFR][NFI];
  longint m_acc = 0;
  bit m_fresh = 1;
  bit pend = 0;
  int exp_q[$];
  string tag_q[$];

  function automatic int requant(longint v, int s);
    longint mag, r;
    mag = (v < 0) ? -v : v;
    if (s >= 0) begin
      r = (mag + ((s > 0) ? (64'sd1 <<< (s - 1)) : 0)) >>> s;
      r = (v < 0) ? -r : r;
    end else r = v <<< (-s);
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, sample before the edge
  task automatic cycle(input bit iv, input int a, input int w, input bit last,
                       input int fr, input int fi, input bit ordy, input string tag);
    bit er;
    in_valid = iv; in_act = 8'(a); in_wgt = 8'(w); in_last = last;
    in_frame = 2'(fr); in_filter = 3'(fi); out_ready = ordy;
    #1;
    er = !(pend && !ordy);
    chk(in_ready === er, "R9 in_ready", longint'(in_ready), longint'(er));
    chk(out_valid === pend, "R4 out_valid", longint'(out_valid), longint'(pend));
    if (pend && ordy && out_valid) begin
      chk(out_data === 8'(exp_q[0]), tag_q[0], longint'(out_data), longint'(exp_q[0]));
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
      pend = 0;
    end
    if (iv && er) begin
      if (m_fresh) m_acc = 0;
      m_acc += longint'(a) * longint'(w);
      m_fresh = last;
      if (last) begin
        exp_q.push_back(requant(m_acc, shadow[fr][fi]));
        tag_q.push_back(tag);
        pend = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit ordy);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, ordy, "R10");
  endtask

  task automatic cfg(input int fr, input int fi, input int s);
    cfg_we = 1; cfg_frame = 2'(fr); cfg_filter = 3'(fi); cfg_shift = 6'(s);
    cycle(0, 0, 0, 0, 0, 0, 1, "R5");
    cfg_we = 0;
    shadow[fr][fi] = s;
  endtask

  task automatic one(input int a, input int w, input int fr, input int fi, input string tag);
    cycle(1, a, w, 1, fr, fi, 1, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NFR; i++) for (int j = 0; j < NFI; j++) shadow[i][j] = 0;
    @(negedge clk); @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 reset in_ready", longint'(in_ready), 1);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: table reset to zero shift
    one(3, 4, 2, 5, "R1 zero shift");
    idle(1, 1);
    // R2, R10: window with gaps
    cycle(1, 10, 3, 0, 0, 0, 1, "R2");
    cycle(0, 99, 99, 0, 0, 0, 1, "R10");
    cycle(1, -7, 2, 0, 0, 0, 1, "R2");
    cycle(1, 5, 5, 1, 0, 0, 1, "R2 gapped window");
    one(-9, 1, 0, 0, "R10 fresh window");
    // R6: rounding
    cfg(1, 1, 2);
    one(6, 1, 1, 1, "R6 6>>2");
    one(-6, 1, 1, 1, "R6 -6>>2");
    one(5, 1, 1, 1, "R6 5>>2");
    one(-5, 1, 1, 1, "R6 -5>>2");
    // R7, R8: left shift and saturation
    cfg(2, 3, -3);
    one(5, 1, 2, 3, "R7 5<<3");
    one(20, 1, 2, 3, "R8 high sat");
    one(-20, 1, 2, 3, "R8 low sat");
    // R5: selection by frame and filter
    cfg(1, 3, 1);
    cfg(1, 4, 4);
    one(100, 1, 1, 3, "R5 entry 1,3");
    one(100, 1, 1, 4, "R5 entry 1,4");
    // R3: full windows of extremes
    cfg(3, 7, 14);
    for (int i = 0; i < MAX_TERMS; i++)
      cycle(1, -128, -128, i == MAX_TERMS - 1, 3, 7, 1, "R3 max positive");
    for (int i = 0; i < MAX_TERMS; i++)
      cycle(1, -128, 127, i == MAX_TERMS - 1, 3, 7, 1, "R3 max negative");
    // R9: stall with terms presented
    one(7, 2, 0, 0, "R9 held result");
    for (int i = 0; i < 4; i++) cycle(1, 50, 50, 1, 0, 0, 0, "R9 ignored");
    cycle(0, 0, 0, 0, 0, 0, 1, "R9");
    one(1, 1, 0, 0, "R9 after stall");
    idle(2, 1);
    // random
    for (int k = 0; k < 60; k++) begin
      int n, fr, fi;
      n = 1 + int'($urandom_range(MAX_TERMS - 1));
      fr = int'($urandom_range(NFR - 1));
      fi = int'($urandom_range(NFI - 1));
      if ($urandom_range(2) == 0) cfg(fr, fi, int'($urandom_range(18)) - 6);
      for (int i = 0; i < n; i++) begin
        while ($urandom_range(4) == 0)
          cycle(0, 0, 0, 0, fr, fi, $urandom_range(3) != 0, "R10 random");
        cycle(1, int'($urandom_range(255)) - 128, int'($urandom_range(255)) - 128,
              i == n - 1, fr, fi, $urandom_range(3) != 0, "R2 random");
      end
    end
    idle(4, 1);
    chk(exp_q.size() == 0, "R4 one result per window", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule